// File: doc/BRIEF.md
# Configuration Pad Ownership Arbiter

This block decides, for every shared configuration pad of the device, whether the pad belongs to the configuration engine or to user GPIO logic. While the device loads its bitstream, every pad stays with the configuration engine. When a configuration succeeds, the block captures a release option for each pin group, together with the low bit of the boot mode. It then hands the released groups to the GPIO logic. The JTAG group has its own rules. Its four test pads can be handed back and forth by a live select pad. When the captured mode bit is set, that reclaim is locked out until the next configuration.

The per-pad owner vector goes to the pad multiplexers. A one selects the configuration path. The block also steers GPIO output and input enables for the pads it releases. The reconfigure pad is a special case: once released, it is forced to work as an output only. The serial and 8-bit parallel configuration pins have no controls of their own. They ride on the slave and master SPI pads, so they follow the release setting of those groups.

The controller has three phases. PH_CFG is the configuration phase and is entered on reset. PH_USER_LIVE is user mode with live JTAG reclaim. PH_USER_LOCK is user mode with the JTAG reclaim locked out. The transitions are:
- CFG_TO_LIVE: `cfg_done` is high, `cfg_enter` is low, and lock is not selected.
- CFG_TO_LOCK: the same, with `rel_opt[0]` high and `boot_mode_lsb` high.
- LIVE_TO_CFG and LOCK_TO_CFG: `cfg_enter` is high.

Top module: `cpo_pad_owner`

## Requirements
- R1: On reset and throughout PH_CFG, all 18 bits of `pad_own_cfg` are 1, and `user_oe` and `user_ie` are all 0.
- R2: The phase leaves PH_CFG only on a clock edge where `cfg_done` is 1 and `cfg_enter` is 0. At that edge `rel_opt` and `boot_mode_lsb` are captured. Later changes to either have no effect on any output until the next such edge.
- R3: In user mode, each single-pad group is released (owner bit 0) when its captured option bit is 1 and is kept (owner bit 1) when that bit is 0. The groups are: the reconfigure pad (index 15, `rel_opt[3]`), READY (index 16, `rel_opt[4]`) and DONE (index 17, `rel_opt[5]`).
- R4: In user mode with captured `rel_opt[0]`=0, the JTAG pads (indices 0..3) have owner 1 and the JTAG select pad (index 4) has owner 0.
- R5: In user mode with captured `rel_opt[0]`=1 and captured `boot_mode_lsb`=0, the select pad keeps owner 1. Pads 0..3 take owner 1 while `jsel_in` is 0 and owner 0 while `jsel_in` is 1, following `jsel_in` in the same cycle.
- R6: With captured `rel_opt[0]`=1 and captured `boot_mode_lsb`=1, pads 0..4 all have owner 0 in user mode and `jsel_in` has no effect on them until configuration is re-entered.
- R7: In user mode, the slave SPI pads (indices 5..9) follow `rel_opt[1]` and the master SPI pads (indices 10..14) follow `rel_opt[2]`. In both cases option 1 gives owner 0. The serial and parallel pins that share these pads have no separate control.
- R8: When `cfg_enter` is 1 in user mode, every owner bit is 1 in that same cycle, and the phase is PH_CFG after the next clock edge.
- R9: A pad with owner 0 has `user_oe` equal to its `gpio_oe_req` bit and `user_ie` equal to 1. The exception is the released reconfigure pad (index 15), which has `user_oe` 1 and `user_ie` 0. A pad with owner 1 has both enables at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enter | input | 1 | Device is (re)entering the configuration state |
| cfg_done | input | 1 | Configuration completed successfully |
| boot_mode_lsb | input | 1 | Low bit of the boot mode pins |
| rel_opt | input | 6 | Per-group release options: JTAG, SSPI, MSPI, reconfigure, READY, DONE (bit 0 upward) |
| jsel_in | input | 1 | Level on the JTAG select pad |
| gpio_oe_req | input | 18 | Output-enable requests from the GPIO logic, one per pad |
| pad_own_cfg | output | 18 | Per-pad owner: 1 = configuration, 0 = GPIO |
| user_oe | output | 18 | GPIO output enable steered to each pad |
| user_ie | output | 18 | GPIO input enable steered to each pad |

## Verification
The bench first walks through all 64 option words with both values of the mode bit. For each combination it checks both levels of the select pad, which separates the keep, live-reclaim and locked cases of the JTAG group. It also confirms that each group answers only to its own option bit. In each pass the option and mode inputs are then inverted while the block is in user mode, which shows whether the captured values or the live inputs drive the outputs. Random traffic then mixes completion pulses with re-entry requests, including cycles where both are high together. This shows whether re-entry takes effect immediately and takes priority over completion. The random GPIO output-enable requests also show whether the reconfigure pad is forced to be an output.

// File: rtl/cpo_pkg.sv
package cpo_pkg;
    localparam int N_JTAG  = 4;
    localparam int N_SSPI  = 5;
    localparam int N_MSPI  = 5;
    localparam int N_GRP   = 6;

    localparam int JTAG_BASE = 0;
    localparam int JSEL_IDX  = JTAG_BASE + N_JTAG;
    localparam int SSPI_BASE = JSEL_IDX + 1;
    localparam int MSPI_BASE = SSPI_BASE + N_SSPI;
    localparam int RECF_IDX  = MSPI_BASE + N_MSPI;
    localparam int RDY_IDX   = RECF_IDX + 1;
    localparam int DONE_IDX  = RDY_IDX + 1;
    localparam int N_PAD     = DONE_IDX + 1;

    localparam int GRP_JTAG = 0;
    localparam int GRP_SSPI = 1;
    localparam int GRP_MSPI = 2;
    localparam int GRP_RECF = 3;
    localparam int GRP_RDY  = 4;
    localparam int GRP_DONE = 5;

    typedef enum logic [1:0] {
        PH_CFG       = 2'd0,
        PH_USER_LIVE = 2'd1,
        PH_USER_LOCK = 2'd2
    } phase_t;

    function automatic int pad_group(input int p);
        if (p < JSEL_IDX)       return GRP_JTAG;
        else if (p == JSEL_IDX) return GRP_JTAG;
        else if (p < MSPI_BASE) return GRP_SSPI;
        else if (p < RECF_IDX)  return GRP_MSPI;
        else if (p == RECF_IDX) return GRP_RECF;
        else if (p == RDY_IDX)  return GRP_RDY;
        else                    return GRP_DONE;
    endfunction
endpackage

// File: rtl/cpo_phase_fsm.sv
module cpo_phase_fsm
    import cpo_pkg::*;
#(
    parameter int NGRP = N_GRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_enter,
    input  logic            cfg_done,
    input  logic            boot_mode_lsb,
    input  logic [NGRP-1:0] rel_opt,
    output phase_t          phase,
    output logic [NGRP-1:0] rel_q
);
    phase_t phase_nx;
    logic   take_user;

    always_comb begin
        take_user = (phase == PH_CFG) && cfg_done && !cfg_enter;
        phase_nx  = phase;
        unique case (phase)
            PH_CFG: begin
                if (take_user)
                    phase_nx = (rel_opt[GRP_JTAG] && boot_mode_lsb) ? PH_USER_LOCK
                                                                    : PH_USER_LIVE;
            end
            PH_USER_LIVE: if (cfg_enter) phase_nx = PH_CFG;
            PH_USER_LOCK: if (cfg_enter) phase_nx = PH_CFG;
            default:      phase_nx = PH_CFG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_CFG;
        else        phase <= phase_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rel_q <= '0;
        else if (take_user) rel_q <= rel_opt;
    end

    // R2
    opt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_CFG && $past(phase != PH_CFG)) |-> $stable(rel_q));

    // R6
    lock_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_USER_LOCK) |-> rel_q[GRP_JTAG]);

    // R8
    reenter_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_CFG && cfg_enter) |=> (phase == PH_CFG));
endmodule

// File: rtl/cpo_own_map.sv
module cpo_own_map
    import cpo_pkg::*;
#(
    parameter int NPAD = N_PAD,
    parameter int NGRP = N_GRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_t          phase,
    input  logic            cfg_enter,
    input  logic [NGRP-1:0] rel_q,
    input  logic            jsel_in,
    output logic [NPAD-1:0] own
);
    logic hold;
    logic jtag_rel;

    always_comb begin
        hold     = (phase == PH_CFG) || cfg_enter;
        jtag_rel = rel_q[GRP_JTAG];
    end

    for (genvar p = 0; p < NPAD; p++) begin : g_pad
        localparam int GRP = pad_group(p);
        if (p < JSEL_IDX) begin : g_jtag
            always_comb begin
                if (hold || !jtag_rel)            own[p] = 1'b1;
                else if (phase == PH_USER_LOCK)   own[p] = 1'b0;
                else                              own[p] = !jsel_in;
            end
        end else if (p == JSEL_IDX) begin : g_jsel
            always_comb own[p] = hold || (jtag_rel && phase == PH_USER_LIVE);
        end else begin : g_plain
            always_comb own[p] = hold || !rel_q[GRP];
        end
    end

    // R1
    cfg_owns_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CFG) |-> (&own));
endmodule

// File: rtl/cpo_oe_steer.sv
module cpo_oe_steer
    import cpo_pkg::*;
#(
    parameter int NPAD = N_PAD
) (
    input  logic [NPAD-1:0] own,
    input  logic [NPAD-1:0] gpio_oe_req,
    output logic [NPAD-1:0] user_oe,
    output logic [NPAD-1:0] user_ie
);
    for (genvar p = 0; p < NPAD; p++) begin : g_pad
        if (p == RECF_IDX) begin : g_out_only
            always_comb begin
                user_oe[p] = !own[p];
                user_ie[p] = 1'b0;
            end
        end else begin : g_bidir
            always_comb begin
                user_oe[p] = !own[p] && gpio_oe_req[p];
                user_ie[p] = !own[p];
            end
        end
    end
endmodule

// File: rtl/cpo_pad_owner.sv
module cpo_pad_owner
    import cpo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enter,
    input  logic              cfg_done,
    input  logic              boot_mode_lsb,
    input  logic [N_GRP-1:0]  rel_opt,
    input  logic              jsel_in,
    input  logic [N_PAD-1:0]  gpio_oe_req,
    output logic [N_PAD-1:0]  pad_own_cfg,
    output logic [N_PAD-1:0]  user_oe,
    output logic [N_PAD-1:0]  user_ie
);
    phase_t             phase;
    logic [N_GRP-1:0]   rel_q;

    cpo_phase_fsm #(.NGRP(N_GRP)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_enter     (cfg_enter),
        .cfg_done      (cfg_done),
        .boot_mode_lsb (boot_mode_lsb),
        .rel_opt       (rel_opt),
        .phase         (phase),
        .rel_q         (rel_q)
    );

    cpo_own_map #(.NPAD(N_PAD), .NGRP(N_GRP)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .cfg_enter (cfg_enter),
        .rel_q     (rel_q),
        .jsel_in   (jsel_in),
        .own       (pad_own_cfg)
    );

    cpo_oe_steer #(.NPAD(N_PAD)) u_steer (
        .own         (pad_own_cfg),
        .gpio_oe_req (gpio_oe_req),
        .user_oe     (user_oe),
        .user_ie     (user_ie)
    );

    // R8
    enter_grabs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enter |-> (&pad_own_cfg));

    // R6
    lock_frees_jtag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_USER_LOCK && !cfg_enter) |-> (pad_own_cfg[JSEL_IDX:JTAG_BASE] == '0));

    // R9
    recf_out_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pad_own_cfg[RECF_IDX] |-> (user_oe[RECF_IDX] && !user_ie[RECF_IDX]));

    // R9
    owned_no_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_own_cfg & (user_oe | user_ie)) == '0));
endmodule

// File: tb/cpo_pad_owner_tb.sv
module cpo_pad_owner_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enter = 1'b0;
    logic        cfg_done = 1'b0;
    logic        boot_mode_lsb = 1'b0;
    logic [5:0]  rel_opt = '0;
    logic        jsel_in = 1'b0;
    logic [17:0] gpio_oe_req = '0;
    logic [17:0] pad_own_cfg, user_oe, user_ie;

    int n_vec = 0;
    int n_bad = 0;
    int m_ph  = 0;
    logic [5:0] m_rel = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpo_pad_owner dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enter(cfg_enter), .cfg_done(cfg_done),
        .boot_mode_lsb(boot_mode_lsb), .rel_opt(rel_opt), .jsel_in(jsel_in),
        .gpio_oe_req(gpio_oe_req), .pad_own_cfg(pad_own_cfg),
        .user_oe(user_oe), .user_ie(user_ie)
    );

    function automatic logic [17:0] f_own(int ph, logic [5:0] r, logic en, logic js);
        logic [17:0] o;
        if (ph == 0 || en) return '1;
        o[3:0]   = !r[0] ? 4'hF : ((ph == 2) ? 4'h0 : {4{!js}});
        o[4]     = r[0] && (ph == 1);
        o[9:5]   = {5{!r[1]}};
        o[14:10] = {5{!r[2]}};
        o[15]    = !r[3];
        o[16]    = !r[4];
        o[17]    = !r[5];
        return o;
    endfunction

    function automatic logic [17:0] f_oe(logic [17:0] o, logic [17:0] req);
        logic [17:0] e;
        for (int p = 0; p < 18; p++) e[p] = !o[p] && ((p == 15) ? 1'b1 : req[p]);
        return e;
    endfunction

    function automatic logic [17:0] f_ie(logic [17:0] o);
        logic [17:0] e;
        for (int p = 0; p < 18; p++) e[p] = !o[p] && (p != 15);
        return e;
    endfunction

    task automatic cmp(string tag, string what, logic [17:0] act, logic [17:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%05h expected=%05h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string force_tag);
        logic [17:0] eo;
        string tj, ts, tp, hold_tag;
        eo = f_own(m_ph, m_rel, cfg_enter, jsel_in);
        hold_tag = (m_ph == 0) ? "R1" : "R8";
        if (m_ph == 0 || cfg_enter) begin
            tj = hold_tag; ts = hold_tag; tp = hold_tag;
        end else begin
            tj = !m_rel[0] ? "R4" : ((m_ph == 2) ? "R6" : "R5");
            ts = "R7";
            tp = "R3";
        end
        if (force_tag != "") begin tj = force_tag; ts = force_tag; tp = force_tag; end
        cmp(tj, "jtag_own", {13'd0, pad_own_cfg[4:0]}, {13'd0, eo[4:0]});
        cmp(ts, "spi_own", {8'd0, pad_own_cfg[14:5]}, {8'd0, eo[14:5]});
        cmp(tp, "single_own", {15'd0, pad_own_cfg[17:15]}, {15'd0, eo[17:15]});
        cmp("R9", "user_oe", user_oe, f_oe(eo, gpio_oe_req));
        cmp("R9", "user_ie", user_ie, f_ie(eo));
    endtask

    task automatic step(logic en, logic dn, logic m0, logic [5:0] r, logic js,
                        logic [17:0] req, string force_tag);
        @(negedge clk);
        cfg_enter = en; cfg_done = dn; boot_mode_lsb = m0;
        rel_opt = r; jsel_in = js; gpio_oe_req = req;
        #1;
        check_all(force_tag);
        @(posedge clk);
        if (m_ph == 0) begin
            if (dn && !en) begin
                m_rel = r;
                m_ph  = (r[0] && m0) ? 2 : 1;
            end
        end else if (en) begin
            m_ph = 0;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'hC0F1_5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check_all("R1");
        rst_n = 1'b1;

        for (int c = 0; c < 128; c++) begin
            logic [5:0] r;
            logic m0;
            r  = c[5:0];
            m0 = c[6];
            step(1'b1, 1'b0, m0, r, 1'b0, 18'h3FFFF, "");
            step(1'b0, 1'b1, m0, r, 1'b0, 18'h2AAAA, "");
            step(1'b0, 1'b0, m0, r, 1'b0, 18'h15555, "");
            step(1'b0, 1'b0, m0, r, 1'b1, 18'h3FFFF, "");
            step(1'b0, 1'b1, ~m0, ~r, 1'b1, 18'h00000, "R2");
            step(1'b1, 1'b1, m0, r, 1'b0, 18'h3FFFF, "");
        end

        for (int i = 0; i < 3000; i++) begin
            logic en, dn;
            en = ($urandom % 10) == 0;
            dn = ($urandom % 3) == 0;
            step(en, dn, 1'($urandom), 6'($urandom), 1'($urandom), 18'($urandom), "");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule